// File: doc/BRIEF.md
# Multi-core CPU configuration register block

A memory-mapped control block for a cluster of up to four processor cores, reached over a simple 32-bit register bus that decodes a 1 KiB window. Each core has three registers: one that launches it, one that reads as its control word and one that reports its status. The block also keeps a general control word, a standby flag, a launch entry address, a counter control word and a free-running 64-bit counter. Software reads the counter as two 32-bit halves and can move its visible value.

A bus access is a single cycle with `req` high. Read data and the error flag are registered and appear in the cycle after the access. Writing a nonzero value to a core's launch register sends a one-cycle, one-hot start pulse to that core. The stored entry address and the fixed start privilege level (3) are presented with the pulse. Power sequencing, clock gating and debug hardware stay outside this block.

Top module: `cpu_cluster_cfg`

## Requirements
- R1: After reset these registers read as follows: general control (0x184) 0x00000020, standby flag (0x1A0) 0, entry address (0x1A4) 0, counter control (0x280) 0. `start` and `err` are 0 and `rdata` is 0.
- R2: The general control, standby flag, entry address and counter control registers return the full 32-bit value last written to them.
- R3: Each read returns a fixed value:
  - core n's launch register (offset 0x40·(n+1)) returns 0x3.
  - core n's control register (launch + 4) returns 0.
  - core n's status register (launch + 8) returns 0x1.
  - 0x000 and 0x140 return 0x1.
  - 0x144 returns 0x10F (bit 8 plus one bit per core).
  - 0x1E4 returns 0.
- R4: Writes to the fixed-value registers of R3 are accepted without error and change no later read.
- R5: A nonzero write to core n's launch register sets only bit n of `start`, in the cycle after the access and for that cycle only. The core index is (offset − 0x40) >> 6. `start_addr` shows the stored entry address and `start_level` is 3.
- R6: A zero write to a launch register produces no start pulse.
- R7: The counter counts up by one every clock from 0 at reset. A read of 0x284 returns bits [31:0] of (count + offset), where count is the value sampled at the access edge. The offset is 0 after reset.
- R8: A read of 0x284 captures bits [63:32] of the same sum. A read of 0x288 returns the last captured high half, which is 0 after reset.
- R9: A write of V to 0x284 or 0x288 changes the offset so that, at the write edge, the low or high half of (count + offset) equals V and the other half is unchanged. The visible value then keeps counting from there, carrying from the low half into the high half.
- R10: An access to an offset that no requirement above decodes, or to an address with bits [1:0] nonzero, reads 0, changes no state and raises `err` for the following cycle only.
- R11: `rdata` changes only in the cycle after a read access and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| err | output | 1 | Undecoded access seen in the previous cycle |
| start | output | 4 | One-hot per-core start pulse |
| start_addr | output | 32 | Entry address presented with the start pulse |
| start_level | output | 2 | Privilege level for a started core (always 3) |

## Verification
A wrong stored word appears at `rdata` one cycle after the next read of that offset. A wrong counter offset or captured high half appears only on the next read of the counter halves, so a carry error stays hidden until software reads across the 32-bit boundary. A wrong launch decode appears at once on `start`, as a pulse in the wrong lane, a missing pulse or a pulse on a zero write, in the cycle after the write. A decode hole or overlap appears as `err` asserted when it should not be, or not asserted when it should be, one cycle after the access.

// File: rtl/cpu_cluster_cfg.sv
module cpu_cluster_cfg #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 10,
  parameter logic [31:0] GEN_CTRL_INIT = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err,
  output logic [NCORES-1:0] start,
  output logic [31:0]       start_addr,
  output logic [1:0]        start_level
);
  localparam logic [ADDR_W-1:0] A_CLUS  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_SYS   = ADDR_W'('h140);
  localparam logic [ADDR_W-1:0] A_GATE  = ADDR_W'('h144);
  localparam logic [ADDR_W-1:0] A_GEN   = ADDR_W'('h184);
  localparam logic [ADDR_W-1:0] A_STBY  = ADDR_W'('h1A0);
  localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'('h1A4);
  localparam logic [ADDR_W-1:0] A_DBG   = ADDR_W'('h1E4);
  localparam logic [ADDR_W-1:0] A_CCTL  = ADDR_W'('h280);
  localparam logic [ADDR_W-1:0] A_CLO   = ADDR_W'('h284);
  localparam logic [ADDR_W-1:0] A_CHI   = ADDR_W'('h288);
  localparam logic [ADDR_W:0]   CORE_LO = (ADDR_W+1)'(64);
  localparam logic [ADDR_W:0]   CORE_HI = (ADDR_W+1)'(64 * (NCORES + 1));
  localparam logic [31:0]       GATE_VAL = 32'h100 | ((32'h1 << NCORES) - 32'h1);

  logic [31:0] gen_q, stby_q, entry_q, cctl_q;
  logic [63:0] cnt_q, delta_q, vis;
  logic [31:0] hi_snap_q, rval;
  logic        hit, in_core, launch_wr;
  logic [ADDR_W-7:0] core_idx;

  assign vis       = cnt_q + delta_q;
  assign in_core   = ({1'b0, addr} >= CORE_LO) && ({1'b0, addr} < CORE_HI);
  assign core_idx  = addr[ADDR_W-1:6] - (ADDR_W-6)'(1);
  assign launch_wr = req && we && in_core && (addr[5:0] == 6'h00) && (wdata != 32'h0);
  assign start_addr  = entry_q;
  assign start_level = 2'd3;

  always_comb begin
    hit  = 1'b1;
    rval = 32'h0;
    if (in_core) begin
      case (addr[5:0])
        6'h00:   rval = 32'h3;
        6'h04:   rval = 32'h0;
        6'h08:   rval = 32'h1;
        default: hit = 1'b0;
      endcase
    end else begin
      case (addr)
        A_CLUS, A_SYS: rval = 32'h1;
        A_GATE:  rval = GATE_VAL;
        A_GEN:   rval = gen_q;
        A_STBY:  rval = stby_q;
        A_ENTRY: rval = entry_q;
        A_DBG:   rval = 32'h0;
        A_CCTL:  rval = cctl_q;
        A_CLO:   rval = vis[31:0];
        A_CHI:   rval = hi_snap_q;
        default: hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q     <= GEN_CTRL_INIT;
      stby_q    <= '0;
      entry_q   <= '0;
      cctl_q    <= '0;
      cnt_q     <= '0;
      delta_q   <= '0;
      hi_snap_q <= '0;
      rdata     <= '0;
      err       <= 1'b0;
      start     <= '0;
    end else begin
      cnt_q <= cnt_q + 64'd1;
      err   <= req && !hit;
      start <= launch_wr ? (NCORES'(1) << core_idx) : '0;
      if (req && !we) begin
        rdata <= rval;
        if (addr == A_CLO) hi_snap_q <= vis[63:32];
      end
      if (req && we) begin
        case (addr)
          A_GEN:   gen_q   <= wdata;
          A_STBY:  stby_q  <= wdata;
          A_ENTRY: entry_q <= wdata;
          A_CCTL:  cctl_q  <= wdata;
          A_CLO:   delta_q <= {vis[63:32], wdata} - cnt_q;
          A_CHI:   delta_q <= {wdata, vis[31:0]} - cnt_q;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cpu_cluster_cfg_chk.sv
module cpu_cluster_cfg_chk #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              err,
  input logic [NCORES-1:0] start
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start)); // R5
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start != '0) |-> $past(req && we && wdata != 32'h0)); // R5
  AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && wdata == 32'h0) |=> (start == '0)); // R6
  AST_LAUNCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr == ADDR_W'('h40)) |=> (rdata == 32'h3 && !err)); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req)); // R10
  AST_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr[1:0] != 2'b00) |=> (rdata == 32'h0 && err)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> $stable(rdata)); // R11
endmodule

bind cpu_cluster_cfg cpu_cluster_cfg_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .err(err), .start(start)
);

// File: tb/test_cpu_cluster_cfg.sv
module test_cpu_cluster_cfg;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, start_addr;
  logic        err;
  logic [3:0]  start;
  logic [1:0]  start_level;

  cpu_cluster_cfg i_cpu_cluster_cfg (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err), .start(start), .start_addr(start_addr),
    .start_level(start_level)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic [63:0] mcnt = '0, mdelta = '0;
  logic [31:0] mhi = '0, mgen = 32'h20, mstb = '0, ment = '0, mcc = '0;
  logic [31:0] exp_rdata = '0, exp_saddr = '0;
  logic [3:0]  exp_start = '0;
  logic        exp_err = 1'b0;

  always @(posedge clk) mcnt <= rst_n ? mcnt + 64'd1 : 64'd0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(start == exp_start, "start", 64'(start), 64'(exp_start));
      chk(err == exp_err, "err", 64'(err), 64'(exp_err));
      chk(rdata == exp_rdata, "rdata", 64'(rdata), 64'(exp_rdata));
      chk(start_level == 2'd3, "start_level", 64'(start_level), 64'd3);
      if (exp_start != '0) chk(start_addr == exp_saddr, "start_addr", 64'(start_addr), 64'(exp_saddr));
      exp_start = '0;
      exp_err   = 1'b0;
    end
  end

  function automatic bit m_hit(input logic [9:0] a);
    if (a[1:0] != 2'b00) return 1'b0;
    if (a >= 10'h040 && a < 10'h140) return (a[5:0] == 6'h00 || a[5:0] == 6'h04 || a[5:0] == 6'h08);
    return (a == 10'h000 || a == 10'h140 || a == 10'h144 || a == 10'h184 || a == 10'h1A0 ||
            a == 10'h1A4 || a == 10'h1E4 || a == 10'h280 || a == 10'h284 || a == 10'h288);
  endfunction

  task automatic acc(input bit w, input logic [9:0] a, input logic [31:0] d);
    logic [63:0] vis;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    vis = mcnt + mdelta;
    exp_err = !m_hit(a);
    if (!w) begin
      exp_rdata = 32'h0;
      if (m_hit(a)) begin
        if (a >= 10'h040 && a < 10'h140)
          exp_rdata = (a[5:0] == 6'h00) ? 32'h3 : (a[5:0] == 6'h08) ? 32'h1 : 32'h0;
        else case (a)
          10'h000, 10'h140: exp_rdata = 32'h1;
          10'h144: exp_rdata = 32'h10F;
          10'h184: exp_rdata = mgen;
          10'h1A0: exp_rdata = mstb;
          10'h1A4: exp_rdata = ment;
          10'h280: exp_rdata = mcc;
          10'h284: begin exp_rdata = vis[31:0]; mhi = vis[63:32]; end
          10'h288: exp_rdata = mhi;
          default: exp_rdata = 32'h0;
        endcase
      end
    end else if (m_hit(a)) begin
      if (a >= 10'h040 && a < 10'h140 && a[5:0] == 6'h00 && d != 0) begin
        exp_start = 4'b0001 << ((a - 10'h040) >> 6);
        exp_saddr = ment;
      end
      case (a)
        10'h184: mgen = d;
        10'h1A0: mstb = d;
        10'h1A4: ment = d;
        10'h280: mcc = d;
        10'h284: mdelta = {vis[63:32], d} - mcnt;
        10'h288: mdelta = {d, vis[31:0]} - mcnt;
        default: ;
      endcase
    end
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    tag = "R1"; idle(2);
    acc(0, 10'h184, 0); acc(0, 10'h1A0, 0); acc(0, 10'h1A4, 0); acc(0, 10'h280, 0);
    tag = "R8"; acc(0, 10'h288, 0);

    tag = "R2";
    acc(1, 10'h184, 32'hDEAD_BEEF); acc(1, 10'h1A0, 32'h0000_0001);
    acc(1, 10'h1A4, 32'h4000_1000); acc(1, 10'h280, 32'hA5A5_5A5A);
    acc(0, 10'h184, 0); acc(0, 10'h1A0, 0); acc(0, 10'h1A4, 0); acc(0, 10'h280, 0);

    tag = "R3";
    for (int n = 0; n < 4; n++) begin
      acc(0, 10'(64 * (n + 1)), 0); acc(0, 10'(64 * (n + 1) + 4), 0); acc(0, 10'(64 * (n + 1) + 8), 0);
    end
    acc(0, 10'h000, 0); acc(0, 10'h140, 0); acc(0, 10'h144, 0); acc(0, 10'h1E4, 0);
    tag = "R11"; idle(4);

    tag = "R4";
    acc(1, 10'h000, 32'hFFFF_FFFF); acc(1, 10'h140, 32'h0); acc(1, 10'h144, 32'h0);
    acc(1, 10'h1E4, 32'hFFFF_FFFF); acc(1, 10'h044, 32'hFFFF_FFFF); acc(1, 10'h0C8, 32'h0);
    acc(0, 10'h144, 0); acc(0, 10'h1E4, 0); acc(0, 10'h044, 0); acc(0, 10'h0C8, 0);
    acc(0, 10'h184, 0);

    tag = "R5";
    for (int n = 0; n < 4; n++) begin
      acc(1, 10'h1A4, 32'h8000_0000 + 32'(n) * 32'h100);
      acc(1, 10'(64 * (n + 1)), 32'(n + 1));
      idle(2);
    end
    acc(1, 10'h080, 32'h1); acc(1, 10'h0C0, 32'h1);

    tag = "R6";
    acc(1, 10'h040, 32'h0); acc(1, 10'h100, 32'h0); idle(2);

    tag = "R7";
    acc(0, 10'h284, 0); idle(5); acc(0, 10'h284, 0); acc(0, 10'h284, 0);
    tag = "R8"; acc(0, 10'h288, 0);

    tag = "R9";
    acc(1, 10'h288, 32'h1234_5678); acc(0, 10'h284, 0); acc(0, 10'h288, 0);
    acc(1, 10'h284, 32'hFFFF_FFF0); idle(20); acc(0, 10'h284, 0); acc(0, 10'h288, 0);
    acc(1, 10'h288, 32'h0); acc(0, 10'h284, 0); acc(0, 10'h288, 0);

    tag = "R10";
    acc(0, 10'h3FC, 0); acc(0, 10'h042, 0); acc(0, 10'h04C, 0); acc(0, 10'h181, 0);
    acc(1, 10'h185, 32'h1111_1111); acc(1, 10'h041, 32'h1); acc(1, 10'h1A8, 32'h5);
    idle(2); acc(0, 10'h184, 0);

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule